// File: doc/BRIEF.md
# Multichannel Phase-Angle Lamp Dimmer

This block dims a bank of incandescent lamp channels by phase-angle control of triacs. A detector on the AC mains gives a zero-crossing signal that is not related to the logic clock. The block synchronizes that signal, and each rising edge starts a new half-cycle phase timer. The timer advances once per microsecond tick, and a free-running prescaler that is realigned at every crossing produces that tick. Each channel holds an 8-bit brightness code that a host writes through a simple write port. Brighter codes fire earlier in the half cycle. When a channel's delay is reached, its gate output pulses low for a short, fixed time. The triac then conducts until its current falls to zero at the end of the half cycle, so the block never issues a turn-off.

Channels with the same code would otherwise switch at the same instant. To avoid this, each channel's firing point is shifted later by its index times a small stagger. A new code takes effect only at the next crossing, so a half cycle never fires twice. If crossings stop arriving, a watchdog blocks all gate pulses until a crossing returns.

Top module: `triac_dimmer`

## Requirements
- R1: Every gate output is active low. All outputs are high (1) while reset is asserted, and they stay high until the first zero crossing has been detected.
- R2: `zc_in` passes through a two-flop synchronizer. A low-to-high transition seen at the synchronizer output restarts the phase timer and the tick prescaler at the third rising clock edge after `zc_in` rises. A falling edge or a steady level has no effect.
- R3: Channel c fires when the phase count reaches `(255 - code) * STEP_TICKS + c * STAGGER_TICKS` ticks, where one tick is `CLK_PER_TICK` clock cycles. The gate output falls one clock edge after the timer reaches that count.
- R4: Each firing holds the gate low for exactly `PULSE_TICKS * CLK_PER_TICK` cycles. A channel fires at most once per half cycle and shows no further gate activity until the next crossing.
- R5: A channel whose active code is 0 never drives its gate low.
- R6: Channels with equal codes are offset from one another by `STAGGER_TICKS` ticks per channel index, with channel 0 earliest.
- R7: A write (`wr_en` high, `wr_ch` selects the channel, `wr_code` gives the code) updates a pending value only. The firing of the current half cycle is unchanged, and the pending code becomes active at the next crossing.
- R8: If the phase timer reaches `WDOG_TICKS` ticks without a crossing, all gate outputs are held high. Any firing point at or beyond that count is suppressed. Normal firing resumes at the next crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_in | input | 1 | Mains zero-crossing detector output, asynchronous |
| wr_en | input | 1 | Brightness write strobe |
| wr_ch | input | $clog2(NCH) | Channel index for the write |
| wr_code | input | 8 | Brightness code, 0 = off, 255 = brightest |
| gate_n | output | NCH | Active-low gate drive, one bit per channel |

## Verification
The bench builds the block with four channels, a two-cycle tick, a step of 5 ticks, a 3-tick pulse, a 2-tick stagger and a 1100-tick watchdog. With these values a full half cycle takes only a few thousand clock cycles. They also place the firing points of the dimmest codes beyond the watchdog limit, so R8 can be observed within ordinary half cycles as well as during a deliberately long gap. The short stagger makes pulses on channels with equal codes overlap in part, which exercises the per-channel offset at the resolution of a single tick.

// File: rtl/triac_dimmer.sv
module triac_dimmer #(
  parameter int NCH           = 8,
  parameter int CLK_PER_TICK  = 200,
  parameter int STEP_TICKS    = 33,
  parameter int PULSE_TICKS   = 20,
  parameter int STAGGER_TICKS = 10,
  parameter int WDOG_TICKS    = 12000,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PSW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1,
  localparam int PHW = $clog2(WDOG_TICKS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           zc_in,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [7:0]     wr_code,
  output logic [NCH-1:0] gate_n
);

  logic           zc_s1, zc_s2, zc_d;
  logic [PSW-1:0] presc;
  logic [PHW-1:0] phase;
  logic           valid;
  logic [7:0]     pend [NCH];
  logic [7:0]     act  [NCH];
  logic [NCH-1:0] fire;
  logic [NCH-1:0] idle_ch;

  wire zc_rise = zc_s2 & ~zc_d;
  wire tick    = (presc == PSW'(CLK_PER_TICK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_s1 <= 1'b0;
      zc_s2 <= 1'b0;
      zc_d  <= 1'b0;
    end else begin
      zc_s1 <= zc_in;
      zc_s2 <= zc_s1;
      zc_d  <= zc_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      phase <= '0;
      valid <= 1'b0;
    end else if (zc_rise) begin
      presc <= '0;
      phase <= '0;
      valid <= 1'b1;
    end else begin
      presc <= tick ? '0 : presc + 1'b1;
      if (tick && phase != PHW'(WDOG_TICKS))
        phase <= phase + 1'b1;
      if (tick && phase == PHW'(WDOG_TICKS - 1))
        valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        pend[c] <= 8'd0;
        act[c]  <= 8'd0;
      end
    end else begin
      if (wr_en && int'(wr_ch) < NCH)
        pend[wr_ch] <= wr_code;
      if (zc_rise)
        for (int c = 0; c < NCH; c++)
          act[c] <= pend[c];
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      automatic int tgt = (255 - int'(act[c])) * STEP_TICKS + c * STAGGER_TICKS;
      automatic int ph  = int'(phase);
      idle_ch[c] = (act[c] == 8'd0);
      fire[c]    = !idle_ch[c] && valid && ph >= tgt && ph < tgt + PULSE_TICKS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_n <= '1;
    else        gate_n <= ~fire;
  end

endmodule

module triac_dimmer_chk #(
  parameter int NCH = 8,
  parameter int PHW = 14,
  parameter int PULSE_CYC = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           zc_rise,
  input logic           valid,
  input logic [PHW-1:0] phase,
  input logic [NCH-1:0] idle_ch,
  input logic [NCH-1:0] gate_n
);

  // R2
  zc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zc_rise |=> phase == '0);

  // R8
  wdog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> &gate_n);

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_rise |=> $stable(idle_ch));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R5
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_ch[c] |=> gate_n[c]);
    if (PULSE_CYC >= 2) begin : g_w
      // R4
      pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_n[c]) |=> !gate_n[c]);
    end
  end

endmodule

bind triac_dimmer triac_dimmer_chk #(
  .NCH(NCH), .PHW(PHW), .PULSE_CYC(PULSE_TICKS * CLK_PER_TICK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .zc_rise(zc_rise), .valid(valid),
  .phase(phase), .idle_ch(idle_ch), .gate_n(gate_n)
);

// File: tb/triac_dimmer_bench.sv
module triac_dimmer_bench;
  localparam int NCH = 4, CPT = 2, STEP = 5, PULSE = 3, STAG = 2, WDOG = 1100;
  localparam int HC = 1300;

  logic clk = 1'b0, rst_n = 1'b0, zc_in = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [7:0] wr_code = '0;
  logic [NCH-1:0] gate_n;

  always #2.5 clk = ~clk;

  triac_dimmer #(.NCH(NCH), .CLK_PER_TICK(CPT), .STEP_TICKS(STEP),
    .PULSE_TICKS(PULSE), .STAGGER_TICKS(STAG), .WDOG_TICKS(WDOG)) u_triac_dimmer (
    .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .wr_en(wr_en),
    .wr_ch(wr_ch), .wr_code(wr_code), .gate_n(gate_n));

  int errors = 0, checks = 0, cyc = 0, e3 = 0, pend_e3 = -1;
  bit seen = 0, done = 0;
  int pm [NCH], am [NCH];
  logic [NCH-1:0] exp_now = '1, exp_next = '1, bad = '0;
  int bad_cyc [NCH];
  logic bad_act [NCH];

  function automatic int fire_tick(int c, int code);
    return (255 - code) * STEP + c * STAG;
  endfunction

  function automatic logic model_gate(int c, int code, int ph);
    int t = fire_tick(c, code);
    return !(seen && code != 0 && ph < WDOG && ph >= t && ph < t + PULSE);
  endfunction

  task automatic step();
    int ph;
    @(posedge clk);
    cyc++;
    exp_now = exp_next;
    if (cyc == pend_e3) begin
      e3 = cyc; seen = 1;
      for (int c = 0; c < NCH; c++) am[c] = pm[c];
    end
    ph = (cyc - e3) / CPT;
    if (ph > WDOG) ph = WDOG;
    for (int c = 0; c < NCH; c++) exp_next[c] = rst_n ? model_gate(c, am[c], ph) : 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++)
      if (gate_n[c] !== exp_now[c] && !bad[c]) begin
        bad[c] = 1'b1; bad_cyc[c] = cyc; bad_act[c] = gate_n[c];
      end
  endtask

  task automatic report(string req);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (bad[c]) begin
        errors++;
        $display("FAIL %s ch%0d cycle %0d: gate_n actual=%b expected=%b",
                 req, c, bad_cyc[c], bad_act[c], ~bad_act[c]);
      end
    end
    bad = '0;
  endtask

  task automatic wr(int c, int code);
    wr_en = 1'b1; wr_ch = 2'(c); wr_code = 8'(code);
    pm[c] = code;
    step();
    wr_en = 1'b0;
  endtask

  task automatic half(int ticks, string req, bit mid_write);
    zc_in = 1'b1; pend_e3 = cyc + 3;
    for (int i = 0; i < 100; i++) step();
    zc_in = 1'b0;
    for (int i = 100; i < ticks * CPT; i++) begin
      if (mid_write && i == 500) begin
        for (int c = 0; c < NCH; c++) wr(c, $urandom_range(255, 1));
        i += NCH;
      end
      step();
    end
    report(req);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin pm[c] = 0; am[c] = 0; end
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    checks++;
    if (gate_n !== '1) begin
      errors++;
      $display("FAIL R1 reset: actual=%b expected=%b", gate_n, 4'hF);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 300; i++) step();
    report("R1 before first crossing");
    wr(0, 255); wr(1, 128); wr(2, 1); wr(3, 0);
    half(HC, "R2 R3 R5 directed", 0);
    for (int c = 0; c < NCH; c++) wr(c, 200);
    half(HC, "R6 equal codes", 0);
    half(HC, "R4 single pulse", 1);
    half(HC, "R7 after mid-cycle write", 0);
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < NCH; c++)
        wr(c, ($urandom_range(7) == 0) ? 0 : $urandom_range(255, 1));
      half(HC, "R3 R4 R7 random", k[0]);
    end
    wr(0, 30); wr(1, 40); wr(2, 20); wr(3, 45);
    half(1500, "R8 long gap", 0);
    wr(0, 250); wr(1, 60); wr(2, 180); wr(3, 100);
    half(HC, "R8 resume", 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule